// File: doc/BRIEF.md
# Grid Snake Game Controller

This block holds the complete game state of a snake game played on an 8 by 8 grid of two-colour lamps. Every grid cell is a small state machine. A cell stores either nothing, an apple, or a body segment with a remaining-life count. A cell decides by itself that it becomes the new head: it does so when the neighbour that lies behind it in the current direction of travel holds the head. The top level only reduces per-cell flags to find out whether the move eats the apple or hits the body. It also keeps the length, the score and the game-over flag.

Moves happen on a movement tick whose period the speed-select input sets. Four direction buttons steer the snake. Apples are placed by a free-running linear feedback shift register. The register draws again on each following clock until it proposes an empty cell. The outputs are two 64-bit bitmaps, one for the snake and one for the apple, a score count and a game-over flag. Driving the lamp matrix and debouncing the buttons are left to the surrounding logic.

Top module: `snake_grid_game`

## Requirements
- R1: After reset the snake occupies row INIT_ROW, columns 0 to INIT_LEN-1, with the head in the rightmost column, and travels right. The score is 0 and game_over is 0. Bitmap bit index is y*8+x, with x growing to the right and y growing downward.
- R2: The snake advances exactly one cell per movement tick, and ticks are TICK_UNIT*(speed_sel+1) clock cycles apart.
- R3: A button press sets the direction used at the next move. When several buttons are pressed together, up wins over down, down over left, and left over right.
- R4: A request for the direction exactly opposite to the one used at the last move is ignored.
- R5: A head that leaves the grid on one edge re-enters at the opposite edge of the same row or column.
- R6: On a move without eating, the tail cell is vacated and the length stays the same.
- R7: When the head enters the apple cell, the score rises by one and the snake grows by one segment, because its tail stays in place on that move. At all times the number of snake cells equals INIT_LEN plus the score.
- R8: At most one apple cell is lit, never on a snake cell. After reset or after an apple is eaten, a new apple is placed on an empty cell within a few clock cycles, and proposals that land on the snake are discarded.
- R9: A move whose target cell is a body segment other than the tail segment ends the game: game_over rises, and that move is not performed.
- R10: Once game_over is set it stays set. The bitmaps and the score then no longer change, and button presses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| speed_sel | input | SPD_W (2) | Move period select, period = TICK_UNIT*(speed_sel+1) cycles |
| btn_up | input | 1 | Request travel upward (y decreasing) |
| btn_down | input | 1 | Request travel downward |
| btn_left | input | 1 | Request travel left (x decreasing) |
| btn_right | input | 1 | Request travel right |
| green_map | output | 64 | Snake cells, bit y*8+x |
| red_map | output | 64 | Apple cell, bit y*8+x |
| score | output | 7 | Apples eaten since reset |
| game_over | output | 1 | Set by a self collision, held until reset |

## Verification
The bench runs its own model of the body as an ordered position list. It drives the snake across all four edges and checks that each head cell matches a table of expected positions. A design that wrapped wrongly or obeyed a reversing request would put the head in another cell. A simultaneous up-and-left press checks the button priority. The bench steers toward two apples and checks growth and score, so a design that also dropped the tail on the eating move would show one cell too few. A tight four-turn loop drives the head into its own body. A design that missed the collision, or still moved or counted after it, would show a changed bitmap or a low game_over flag. The apple is checked after every move to be alone and off the body, which catches a placer that accepts an occupied proposal.

// File: rtl/snk_pkg.sv
// Shared types for the grid snake game.
// Assumes a two-bit direction code in which a direction and its
// opposite differ only in bit 0.
package snk_pkg;

    typedef enum logic [1:0] {
        DIR_UP    = 2'd0,
        DIR_DOWN  = 2'd1,
        DIR_LEFT  = 2'd2,
        DIR_RIGHT = 2'd3
    } dir_t;

    // Opposite direction of d.
    function automatic dir_t dir_opposite(input dir_t d);
        return dir_t'(d ^ 2'b01);
    endfunction

endpackage

// File: rtl/snk_tick.sv
// Movement tick generator.
// Emits a one-cycle tick every TICK_UNIT*(spd+1) cycles.
// Assumes that a speed change may shorten the period in progress.
module snk_tick #(
    parameter int TICK_UNIT = 250000,
    parameter int SPD_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SPD_W-1:0] spd,
    output logic             tick
);
    localparam int CNT_W = $clog2(TICK_UNIT * (2 ** SPD_W) + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Last count value of the selected period.
    always_comb begin
        limit = CNT_W'(TICK_UNIT) * (CNT_W'(spd) + CNT_W'(1)) - CNT_W'(1);
        tick  = (cnt_q >= limit);
    end

    // Count cycles, restart after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/snk_lfsr.sv
// Free-running Fibonacci LFSR used to propose apple cells.
// Assumes IDX_W <= W; the proposal folds high and low bits together.
module snk_lfsr #(
    parameter int         W     = 8,
    parameter int         IDX_W = 6,
    parameter logic [W-1:0] TAPS = 8'hB8,
    parameter logic [W-1:0] SEED = 8'h5A
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [IDX_W-1:0] cand
);
    logic [W-1:0] lfsr_q;

    // Fold the state into a cell index proposal.
    always_comb cand = lfsr_q[IDX_W-1:0] ^ lfsr_q[W-1 -: IDX_W];

    // Advance one step each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= {lfsr_q[W-2:0], ^(lfsr_q & TAPS)};
    end
endmodule

// File: rtl/snk_dir.sv
// Direction control: turns button presses into the direction of the
// next move, with fixed priority and a reverse filter.
// Assumes step marks a performed move and freeze is the game-over flag.
module snk_dir
    import snk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic freeze,
    input  logic btn_up,
    input  logic btn_down,
    input  logic btn_left,
    input  logic btn_right,
    output dir_t move_dir
);
    dir_t cur_q, pend_q, req;
    logic any_btn;

    // Pick the highest-priority pressed button.
    always_comb begin
        any_btn = btn_up | btn_down | btn_left | btn_right;
        if (btn_up)        req = DIR_UP;
        else if (btn_down) req = DIR_DOWN;
        else if (btn_left) req = DIR_LEFT;
        else               req = DIR_RIGHT;
        move_dir = pend_q;
    end

    // Track the last used direction and the pending one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= DIR_RIGHT;
            pend_q <= DIR_RIGHT;
        end else begin
            if (step) cur_q <= pend_q;
            if (any_btn && !freeze && (req != dir_opposite(cur_q)))
                pend_q <= req;
        end
    end
endmodule

// File: rtl/snk_cell.sv
// One grid cell. Holds a body life count (0 = no body) and an apple
// bit. It becomes the head when the neighbour it would be entered from,
// selected by the move direction, holds the head.
// Assumes step is already gated by collision and game over.
module snk_cell
    import snk_pkg::*;
#(
    parameter int          LIFE_W    = 7,
    parameter int          INIT_LIFE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              grow,
    input  logic              place,
    input  logic [LIFE_W-1:0] len,
    input  logic [3:0]        src_head,
    input  dir_t              dir,
    output logic              is_head,
    output logic              enter,
    output logic              occupied,
    output logic              hit,
    output logic              apple
);
    logic [LIFE_W-1:0] life_q;
    logic              apple_q;

    // Neighbour-driven flags seen by the top level.
    always_comb begin
        is_head  = (life_q == len) && (life_q != '0);
        enter    = src_head[dir];
        occupied = (life_q != '0);
        hit      = (life_q > LIFE_W'(1));
        apple    = apple_q;
    end

    // Body life update on a move.
    always_ff @(posedge clk) begin
        if (!rst_n)
            life_q <= LIFE_W'(INIT_LIFE);
        else if (step) begin
            if (enter)
                life_q <= grow ? len + LIFE_W'(1) : len;
            else if ((life_q != '0) && !grow)
                life_q <= life_q - LIFE_W'(1);
        end
    end

    // Apple bit: set by the placer, cleared when eaten.
    always_ff @(posedge clk) begin
        if (!rst_n)              apple_q <= 1'b0;
        else if (step && enter)  apple_q <= 1'b0;
        else if (place)          apple_q <= 1'b1;
    end
endmodule

// File: rtl/snake_grid_game.sv
// Snake game on a GRID_W x GRID_H grid of cell state machines.
// Reduces per-cell flags into eat and collide, keeps length, score and
// game over, and places apples from LFSR proposals on empty cells.
// Assumes INIT_LEN <= GRID_W and INIT_ROW < GRID_H.
module snake_grid_game
    import snk_pkg::*;
#(
    parameter int GRID_W    = 8,
    parameter int GRID_H    = 8,
    parameter int SPD_W     = 2,
    parameter int TICK_UNIT = 250000,
    parameter int INIT_LEN  = 3,
    parameter int INIT_ROW  = 3,
    parameter int LFSR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SPD_W-1:0]     speed_sel,
    input  logic                 btn_up,
    input  logic                 btn_down,
    input  logic                 btn_left,
    input  logic                 btn_right,
    output logic [GRID_W*GRID_H-1:0] green_map,
    output logic [GRID_W*GRID_H-1:0] red_map,
    output logic [$clog2(GRID_W*GRID_H+1)-1:0] score,
    output logic                 game_over
);
    localparam int CELLS  = GRID_W * GRID_H;
    localparam int LIFE_W = $clog2(CELLS + 1);
    localparam int IDX_W  = $clog2(CELLS);

    logic              tick, step, eat, collide;
    dir_t              move_dir;
    logic [LIFE_W-1:0] len_q, score_q;
    logic              over_q, need_q;
    logic [IDX_W-1:0]  cand;
    logic [CELLS-1:0]  head_v, enter_v, occ_v, hit_v, apple_v, place_v;

    snk_tick #(.TICK_UNIT(TICK_UNIT), .SPD_W(SPD_W)) tick_i (
        .clk(clk), .rst_n(rst_n), .spd(speed_sel), .tick(tick)
    );

    snk_lfsr #(.W(LFSR_W), .IDX_W(IDX_W)) lfsr_i (
        .clk(clk), .rst_n(rst_n), .cand(cand)
    );

    snk_dir dir_i (
        .clk(clk), .rst_n(rst_n), .step(step), .freeze(over_q),
        .btn_up(btn_up), .btn_down(btn_down), .btn_left(btn_left),
        .btn_right(btn_right), .move_dir(move_dir)
    );

    // Reduce cell flags into the move outcome.
    always_comb begin
        eat     = |(enter_v & apple_v);
        collide = |(enter_v & hit_v);
        step    = tick && !over_q && !collide;
    end

    // Cell array with wrap-around neighbour wiring.
    for (genvar y = 0; y < GRID_H; y++) begin : g_row
        for (genvar x = 0; x < GRID_W; x++) begin : g_col
            localparam int IDX  = y * GRID_W + x;
            localparam int XM1  = (x + GRID_W - 1) % GRID_W;
            localparam int XP1  = (x + 1) % GRID_W;
            localparam int YM1  = (y + GRID_H - 1) % GRID_H;
            localparam int YP1  = (y + 1) % GRID_H;
            localparam int LIFE0 = ((y == INIT_ROW) && (x < INIT_LEN)) ? x + 1 : 0;

            logic [3:0] src;
            // Neighbour that holds the head before a move in each direction.
            always_comb begin
                src[DIR_UP]    = head_v[YP1 * GRID_W + x];
                src[DIR_DOWN]  = head_v[YM1 * GRID_W + x];
                src[DIR_LEFT]  = head_v[y * GRID_W + XP1];
                src[DIR_RIGHT] = head_v[y * GRID_W + XM1];
                place_v[IDX]   = need_q && !tick && !occ_v[IDX] &&
                                 (cand == IDX_W'(IDX));
            end

            snk_cell #(.LIFE_W(LIFE_W), .INIT_LIFE(LIFE0)) cell_i (
                .clk(clk), .rst_n(rst_n), .step(step), .grow(eat),
                .place(place_v[IDX]), .len(len_q), .src_head(src),
                .dir(move_dir), .is_head(head_v[IDX]), .enter(enter_v[IDX]),
                .occupied(occ_v[IDX]), .hit(hit_v[IDX]), .apple(apple_v[IDX])
            );
        end
    end

    // Length, score, game over and apple request bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q   <= LIFE_W'(INIT_LEN);
            score_q <= '0;
            over_q  <= 1'b0;
            need_q  <= 1'b1;
        end else begin
            if (step && eat) begin
                len_q   <= len_q + LIFE_W'(1);
                score_q <= score_q + LIFE_W'(1);
                need_q  <= 1'b1;
            end else if (|place_v) begin
                need_q  <= 1'b0;
            end
            if (tick && collide) over_q <= 1'b1;
        end
    end

    // Drive the outputs.
    always_comb begin
        green_map = occ_v;
        red_map   = apple_v;
        score     = score_q;
        game_over = over_q;
    end
endmodule

// File: rtl/snk_checker.sv
// Property checker for the grid snake game, bound to the top module.
// Assumes the bitmaps, score and game-over ports of the top module.
module snk_checker #(
    parameter int CELLS    = 64,
    parameter int SCORE_W  = 7,
    parameter int INIT_LEN = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CELLS-1:0]   green,
    input logic [CELLS-1:0]   red,
    input logic [SCORE_W-1:0] score,
    input logic               over
);
    AST_APPLE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(red) <= 1); // R8
    AST_APPLE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (red & green) == '0); // R8
    AST_LEN_MATCHES_SCORE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(green) == INIT_LEN + int'(score)); // R7
    AST_SCORE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (score != $past(score)) |-> (score == $past(score) + SCORE_W'(1))); // R7
    AST_OVER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        over |=> over); // R10
    AST_OVER_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        over |=> ($stable(green) && $stable(score) && $stable(red))); // R10
endmodule

bind snake_grid_game snk_checker #(
    .CELLS(CELLS), .SCORE_W(LIFE_W), .INIT_LEN(INIT_LEN)
) chk_i (
    .clk(clk), .rst_n(rst_n), .green(green_map), .red(red_map),
    .score(score), .over(game_over)
);

// File: tb/snake_grid_game_tb.sv
// Self-checking bench for snake_grid_game with a position-list model.
module snake_grid_game_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int UNIT       = 32;
    localparam int ILEN       = 5;
    localparam int IROW       = 4;
    localparam int NTAB       = 13;
    // Button masks: bit0 up, bit1 down, bit2 left, bit3 right.
    localparam logic [3:0] TB_BTN [NTAB] = '{4'h0, 4'h0, 4'h0, 4'h0, 4'h5,
        4'h2, 4'h1, 4'h0, 4'h0, 4'h4, 4'h0, 4'h2, 4'h8};
    localparam int TB_X [NTAB] = '{5, 6, 7, 0, 0, 0, 0, 0, 0, 7, 6, 6, 7};
    localparam int TB_Y [NTAB] = '{4, 4, 4, 4, 3, 2, 1, 0, 7, 7, 7, 0, 0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  speed_sel = 2'd1;
    logic        bu = 1'b0, bd = 1'b0, bl = 1'b0, br = 1'b0;
    logic [63:0] green_map, red_map;
    logic [6:0]  score;
    logic        game_over;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int q[$];
    int mcur, mpend, mscore;
    bit mover;
    logic [63:0] prev_red;

    always #(CLK_PERIOD / 2) clk = ~clk;

    snake_grid_game #(.TICK_UNIT(UNIT), .INIT_LEN(ILEN), .INIT_ROW(IROW)) dut_i (
        .clk(clk), .rst_n(rst_n), .speed_sel(speed_sel), .btn_up(bu),
        .btn_down(bd), .btn_left(bl), .btn_right(br), .green_map(green_map),
        .red_map(red_map), .score(score), .game_over(game_over)
    );

    task automatic chk(input bit ok, input string msg, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
        end
    endtask

    function automatic logic [63:0] model_map();
        logic [63:0] m = '0;
        foreach (q[i]) m[q[i]] = 1'b1;
        return m;
    endfunction

    task automatic do_reset(input logic [1:0] spd);
        rst_n = 1'b0; {bu, bd, bl, br} = 4'b0; speed_sel = spd;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        q = {};
        for (int x = 0; x < ILEN; x++) q.push_back(IROW * 8 + x);
        mcur = 3; mpend = 3; mscore = 0; mover = 0;
    endtask

    task automatic press(input logic [3:0] m);
        int req;
        if (m == 4'b0) return;
        req = m[0] ? 0 : m[1] ? 1 : m[2] ? 2 : 3;
        if (!mover && req != (mcur ^ 1)) mpend = req;
        @(negedge clk) {br, bl, bd, bu} = m;
        @(negedge clk) {br, bl, bd, bu} = 4'b0;
    endtask

    task automatic wait_move(output bit moved, output int ncyc);
        logic [63:0] last_g = green_map;
        moved = 0; ncyc = 0;
        prev_red = red_map;
        for (int i = 0; i < 16 * UNIT; i++) begin
            @(negedge clk);
            ncyc = i + 1;
            if (green_map != last_g) begin moved = 1; break; end
            prev_red = red_map;
        end
    endtask

    task automatic model_step();
        int hx, hy, idx;
        bit eat, coll;
        hx = q[q.size() - 1] % 8; hy = q[q.size() - 1] / 8;
        mcur = mpend;
        case (mcur)
            0: hy = (hy + 7) % 8;
            1: hy = (hy + 1) % 8;
            2: hx = (hx + 7) % 8;
            default: hx = (hx + 1) % 8;
        endcase
        idx = hy * 8 + hx;
        eat = prev_red[idx];
        coll = 0;
        for (int k = (eat ? 0 : 1); k < q.size(); k++) if (q[k] == idx) coll = 1;
        if (coll) mover = 1;
        else begin
            q.push_back(idx);
            if (eat) mscore++; else void'(q.pop_front());
        end
    endtask

    task automatic step_and_check(input bit apple_chk, input string tag, output int ncyc);
        bit moved;
        wait_move(moved, ncyc);
        model_step();
        chk(moved == !mover, {tag, " R2 move happened"}, moved, !mover);
        chk(green_map == model_map(), {tag, " R6 snake bitmap"}, green_map, model_map());
        chk(score == 7'(mscore), {tag, " R7 score"}, score, mscore);
        chk(game_over == mover, {tag, " R9 game_over"}, game_over, mover);
        if (apple_chk && !mover) begin
            repeat (UNIT) @(negedge clk);
            chk($countones(red_map) == 1 && (red_map & green_map) == '0,
                {tag, " R8 single free apple"}, red_map, 0);
        end
    endtask

    initial begin
        int n, ax, ay, hx, hy;
        // Reset state
        do_reset(2'd1);
        chk(green_map == model_map(), "R1 reset snake bitmap", green_map, model_map());
        chk(score == 0, "R1 reset score", score, 0);
        chk(game_over == 1'b0, "R1 reset game_over", game_over, 0);

        // Table walk: heading, priority, reverse filter, wrap
        for (int i = 0; i < NTAB; i++) begin
            press(TB_BTN[i]);
            step_and_check(1, $sformatf("table %0d", i), n);
            chk(q[q.size() - 1] == TB_Y[i] * 8 + TB_X[i],
                $sformatf("R3 R4 R5 table %0d head", i), q[q.size() - 1], TB_Y[i] * 8 + TB_X[i]);
        end

        // Speed select sets the move period
        do_reset(2'd0);
        step_and_check(0, "speed0 sync", n);
        step_and_check(0, "speed0", n);
        chk(n == UNIT, "R2 period at speed 0", n, UNIT);
        speed_sel = 2'd3;
        step_and_check(0, "speed3 sync", n);
        step_and_check(0, "speed3", n);
        chk(n == 4 * UNIT, "R2 period at speed 3", n, 4 * UNIT);

        // Steer to two apples
        do_reset(2'd1);
        for (int i = 0; i < 60 && mscore < 2 && !mover; i++) begin
            ax = 0; ay = 0;
            for (int b = 0; b < 64; b++) if (red_map[b]) begin ax = b % 8; ay = b / 8; end
            hx = q[q.size() - 1] % 8; hy = q[q.size() - 1] / 8;
            if (hy != ay) press((mcur == 0) ? 4'h8 : 4'h2);
            else if (hx != ax) press((mcur == 2) ? 4'h2 : 4'h8);
            step_and_check(1, "eat", n);
        end
        chk(mscore == 2 && score == 7'd2, "R7 two apples eaten", score, 2);
        chk($countones(green_map) == ILEN + 2, "R7 grown length", $countones(green_map), ILEN + 2);

        // Self collision with a four-turn loop
        do_reset(2'd1);
        step_and_check(1, "loop right", n);
        press(4'h2); step_and_check(1, "loop down", n);
        press(4'h4); step_and_check(1, "loop left", n);
        press(4'h1); step_and_check(0, "loop up", n);
        chk(game_over == 1'b1, "R9 collision ends game", game_over, 1);

        // Frozen after game over
        begin
            logic [63:0] g0, r0;
            logic [6:0]  s0;
            g0 = green_map; r0 = red_map; s0 = score;
            press(4'h8);
            repeat (3 * 2 * UNIT) @(negedge clk);
            chk(green_map == g0, "R10 snake frozen", green_map, g0);
            chk(red_map == r0, "R10 apple frozen", red_map, r0);
            chk(score == s0, "R10 score frozen", score, s0);
            chk(game_over == 1'b1, "R10 game_over held", game_over, 1);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule